// File: doc/BRIEF.md
# Interprocessor Mailbox

The mailbox lets processors that share a register bus pass 32-bit words to each other. It contains several independent message queues, each a small first-in first-out buffer. A sender writes a word to a queue's message register, and a receiver reads the same register to take the oldest word. Per queue, software can read a full flag and a count of the words held.

Each user (one processor) owns an interrupt status register and an interrupt enable register. Every queue has two event bits in both registers: one for "a word arrived" and one for "space became free". Status bits are set by hardware and cleared by writing ones. A user's interrupt line is high while any status bit it has enabled is set. A soft reset returns all queues and all interrupt state to empty or zero, and a status bit reports when that reset has finished.

Accesses use a single-cycle request port. A read returns its data on `rsp_rdata` in the cycle after the request and holds it until the next read.

Top module: `ipc_mailbox`

## Requirements
- R1: A write to offset 0x040+4*m pushes the write data into queue m. A read of that offset returns the oldest word and removes it, so words leave in the order they arrived.
- R2: Each queue holds at most DEPTH (4) words. A write to a full queue is dropped. Offset 0x080+4*m reads 1 when queue m is full and 0 otherwise.
- R3: Offset 0x0C0+4*m reads the number of words in queue m. A read of an empty queue's message register returns 0 and leaves the count at 0.
- R4: Every accepted push into queue m sets bit 2*m in the status register of every user. Status for user u is at offset 0x100+8*u.
- R5: A read that takes queue m from full to not full sets bit 2*m+1 in the status register of every user.
- R6: Writing to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: The enable register for user u is at 0x104+8*u. It is written and read directly. `irq[u]` is high whenever status and enable of user u share a set bit, starting the cycle after the event or write that caused it.
- R8: Writing a 1 to bit 1 of offset 0x010 starts a soft reset. The reset empties every queue and clears all status and enable bits. Bit 0 of offset 0x014 reads 0 while the reset runs and 1 once it is done, within RST_CYC (3) cycles.
- R9: Offset 0x000 reads the revision, with REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0 (0x20 by default). Writes to it have no effect.
- R10: Read data appears on `rsp_rdata` one cycle after the request and stays stable until the next read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | NUSR (2) | Per-user interrupt line |

## Verification
The bench targets the queue edges. It writes into a full queue: a design that wraps would overwrite the oldest word or corrupt the count. It reads from an empty queue: a design that fails here would return stale data or let the count go below zero. It also checks that the "space became free" event fires only on the transition out of full, so a design that set it on every pop would raise spurious interrupts. Clearing by writing ones is checked with partial masks, where a plain write would wipe bits that are still pending. The soft reset is checked to clear enables as well as queues, so a design that left interrupts armed afterwards is caught.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 9;
    localparam logic [ADDR_W-1:0] OFS_REV   = 9'h000;
    localparam logic [ADDR_W-1:0] OFS_CFG   = 9'h010;
    localparam logic [ADDR_W-1:0] OFS_RSTAT = 9'h014;
    localparam logic [ADDR_W-1:0] OFS_MSG   = 9'h040;
    localparam logic [ADDR_W-1:0] OFS_FULL  = 9'h080;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 9'h0C0;
    localparam logic [ADDR_W-1:0] OFS_IRQ   = 9'h100;
    localparam int CFG_SRST_BIT = 1;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            rp;
        logic [PW-1:0]            wp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign head  = st_q.mem[st_q.rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp           = bump(st_q.wp);
        end
        if (do_pop) begin
            st_d.rp = bump(st_q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r2_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count)));
    a_r3_empty_read_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (count == '0));
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int NQ        = 4,
    parameter int NUSR      = 2,
    parameter int DEPTH     = 4,
    parameter int RST_CYC   = 3,
    parameter int REV_MAJOR = 2,
    parameter int REV_MINOR = 0,
    localparam int SW       = 2 * NQ,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int RCW      = $clog2(RST_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [NUSR-1:0]   irq
);
    typedef struct packed {
        logic [NUSR-1:0][SW-1:0] sts;
        logic [NUSR-1:0][SW-1:0] en;
        logic [DATA_W-1:0]       rdata;
        logic [RCW-1:0]          rcnt;
    } mbx_st_t;

    mbx_st_t st_d, st_q;

    logic                       busy, start, rd, wr;
    logic [NQ-1:0]              q_push, q_pop, q_full, q_empty;
    logic [NQ-1:0][DATA_W-1:0]  q_head;
    logic [NQ-1:0][CW-1:0]      q_cnt;
    logic [SW-1:0]              evt;
    logic [DATA_W-1:0]          rd_val;

    assign busy      = (st_q.rcnt != '0);
    assign rd        = req_valid && !req_write;
    assign wr        = req_valid && req_write;
    assign rsp_rdata = st_q.rdata;

    for (genvar g = 0; g < NQ; g++) begin : g_q
        mbx_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (busy),
            .push  (q_push[g]),
            .pop   (q_pop[g]),
            .din   (req_wdata),
            .head  (q_head[g]),
            .count (q_cnt[g]),
            .full  (q_full[g]),
            .empty (q_empty[g])
        );
    end

    always_comb begin
        st_d   = st_q;
        q_push = '0;
        q_pop  = '0;
        evt    = '0;
        rd_val = '0;
        start  = 1'b0;
        if (req_addr == OFS_REV) rd_val = DATA_W'({4'(REV_MAJOR), 4'(REV_MINOR)});
        if (req_addr == OFS_CFG) begin
            rd_val = DATA_W'({busy, 1'b0});
            start  = wr && req_wdata[CFG_SRST_BIT] && !busy;
        end
        if (req_addr == OFS_RSTAT) rd_val = DATA_W'(!busy);
        for (int m = 0; m < NQ; m++) begin
            if (req_addr == OFS_MSG + ADDR_W'(4 * m)) begin
                rd_val    = q_empty[m] ? '0 : q_head[m];
                q_push[m] = wr;
                q_pop[m]  = rd;
            end
            if (req_addr == OFS_FULL + ADDR_W'(4 * m)) rd_val = DATA_W'(q_full[m]);
            if (req_addr == OFS_CNT + ADDR_W'(4 * m))  rd_val = DATA_W'(q_cnt[m]);
            evt[2*m]   = q_push[m] && !q_full[m];
            evt[2*m+1] = q_pop[m] && q_full[m];
        end
        for (int u = 0; u < NUSR; u++) begin
            if (req_addr == OFS_IRQ + ADDR_W'(8 * u)) begin
                rd_val = DATA_W'(st_q.sts[u]);
                if (wr) st_d.sts[u] = st_q.sts[u] & ~req_wdata[SW-1:0];
            end
            if (req_addr == OFS_IRQ + ADDR_W'(8 * u + 4)) begin
                rd_val = DATA_W'(st_q.en[u]);
                if (wr) st_d.en[u] = req_wdata[SW-1:0];
            end
            st_d.sts[u] = st_d.sts[u] | evt;
        end
        if (rd) st_d.rdata = rd_val;
        if (busy)       st_d.rcnt = st_q.rcnt - 1'b1;
        else if (start) st_d.rcnt = RCW'(RST_CYC);
        if (busy || start) begin
            st_d.sts = '0;
            st_d.en  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int u = 0; u < NUSR; u++) irq[u] = |(st_q.sts[u] & st_q.en[u]);
    end

    for (genvar gu = 0; gu < NUSR; gu++) begin : g_chk_u
        for (genvar gm = 0; gm < NQ; gm++) begin : g_chk_q
            a_r4_new_msg_flag: assert property (@(posedge clk) disable iff (!rst_n)
                (!busy && q_push[gm] && !q_full[gm]) |=> st_q.sts[gu][2*gm]);
            a_r5_not_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
                (!busy && q_pop[gm] && q_full[gm]) |=> st_q.sts[gu][2*gm+1]);
        end
    end
    a_r8_reset_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (irq == '0));
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rsp_rdata));
endmodule

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
    import ipc_mbox_pkg::*;
    localparam int NQ = 4, NUSR = 2, DEPTH = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] rsp_rdata;
    logic [NUSR-1:0]   irq;

    ipc_mailbox dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq(irq));

    int n_chk = 0, n_fail = 0;
    logic [31:0] mm [NQ][DEPTH];
    int          mc [NQ];
    logic [7:0]  m_sts [NUSR];
    logic [7:0]  m_en  [NUSR];

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(a);
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    function automatic logic [NUSR-1:0] exp_irq();
        logic [NUSR-1:0] v;
        for (int u = 0; u < NUSR; u++) v[u] = |(m_sts[u] & m_en[u]);
        return v;
    endfunction

    task automatic model_clear();
        for (int q = 0; q < NQ; q++) mc[q] = 0;
        for (int u = 0; u < NUSR; u++) begin m_sts[u] = '0; m_en[u] = '0; end
    endtask

    task automatic push(input int q, input logic [31:0] d);
        wr(32'h40 + 4*q, d);
        if (mc[q] < DEPTH) begin
            mm[q][mc[q]] = d; mc[q]++;
            for (int u = 0; u < NUSR; u++) m_sts[u][2*q] = 1'b1;
        end
    endtask

    task automatic pop_chk(input int q, input string r);
        logic [31:0] got, exp;
        rd(32'h40 + 4*q, got);
        exp = '0;
        if (mc[q] > 0) begin
            exp = mm[q][0];
            if (mc[q] == DEPTH) for (int u = 0; u < NUSR; u++) m_sts[u][2*q+1] = 1'b1;
            for (int i = 0; i < DEPTH - 1; i++) mm[q][i] = mm[q][i+1];
            mc[q]--;
        end
        check(r, got, exp);
    endtask

    task automatic irq_chk(input string r);
        check(r, 32'(irq), 32'(exp_irq()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        irq_chk("R7 reset");
        rd(32'h000, v); check("R9 revision", v, 32'h20);
        rd(32'h014, v); check("R8 done after reset", v, 32'h1);
        rd(32'h0C0, v); check("R3 count after reset", v, 32'h0);
        wr(32'h000, 32'hFFFF_FFFF);
        rd(32'h000, v); check("R9 revision write ignored", v, 32'h20);
        rd(32'h020, v); check("R10 unmapped", v, 32'h0);

        // directed: fill, overflow, drain, underflow
        wr(32'h104, 32'hFF); m_en[0] = 8'hFF;
        for (int i = 0; i < DEPTH; i++) push(0, 32'hA000_0000 + i);
        irq_chk("R7 new msg irq");
        rd(32'h080, v); check("R2 full flag", v, 32'h1);
        push(0, 32'hDEAD_BEEF);
        rd(32'h0C0, v); check("R2 count after drop", v, 32'(DEPTH));
        pop_chk(0, "R1 order head");
        rd(32'h100, v); check("R5 not-full flag", v, 32'(m_sts[0]));
        rd(32'h080, v); check("R2 not full", v, 32'h0);
        for (int i = 1; i < DEPTH; i++) pop_chk(0, "R1 order");
        pop_chk(0, "R3 empty read");
        rd(32'h0C0, v); check("R3 count empty", v, 32'h0);
        // partial write-one-to-clear
        wr(32'h100, 32'h1); m_sts[0] &= ~8'h01;
        rd(32'h100, v); check("R6 partial clear", v, 32'(m_sts[0]));
        rd(32'h108, v); check("R4 other user flag", v, 32'(m_sts[1]));
        irq_chk("R7 after clear");
        // read hold
        rd(32'h000, v);
        repeat (4) @(negedge clk);
        check("R10 hold", rsp_rdata, 32'h20);

        // constrained random
        for (int n = 0; n < 600; n++) begin
            int op, q, u;
            op = int'($urandom_range(0, 6)); q = int'($urandom_range(0, NQ-1));
            u = int'($urandom_range(0, NUSR-1));
            case (op)
                0, 1: push(q, $urandom());
                2:    pop_chk(q, "R1 random pop");
                3: begin rd(32'hC0 + 4*q, v); check("R3 random count", v, 32'(mc[q])); end
                4: begin rd(32'h80 + 4*q, v); check("R2 random full", v, 32'(mc[q] == DEPTH)); end
                5: begin
                    v = $urandom();
                    if (v[0]) begin wr(32'h104 + 8*u, v); m_en[u] = v[8:1]; m_en[u] = v[7:0]; end
                    else begin wr(32'h100 + 8*u, v); m_sts[u] &= ~v[7:0]; end
                end
                default: begin rd(32'h100 + 8*u, v); check("R4 R5 R6 random status", v, 32'(m_sts[u])); end
            endcase
            irq_chk("R7 random irq");
        end

        // soft reset
        for (int q = 0; q < NQ; q++) push(q, 32'h5500 + q);
        wr(32'h10C, 32'hFF); m_en[1] = 8'hFF;
        wr(32'h010, 32'h2);
        rd(32'h014, v); check("R8 busy", v, 32'h0);
        begin
            int polls = 0;
            do begin rd(32'h014, v); polls++; end while (v != 32'h1 && polls < 10);
            check("R8 done within bound", 32'(polls <= 2), 32'h1);
        end
        model_clear();
        for (int q = 0; q < NQ; q++) begin
            rd(32'hC0 + 4*q, v); check("R8 queue emptied", v, 32'h0);
        end
        for (int u = 0; u < NUSR; u++) begin
            rd(32'h100 + 8*u, v); check("R8 status cleared", v, 32'h0);
            rd(32'h104 + 8*u, v); check("R8 enable cleared", v, 32'h0);
        end
        irq_chk("R8 irq low");
        push(2, 32'h1234_5678);
        pop_chk(2, "R1 after soft reset");

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule